// File: doc/BRIEF.md
# Dual-Mode Panel Pixel Formatter

This block sits between a decoded video stream and the column drivers of a flat panel. Each input clock it takes one 24-bit RGB pixel, with its data-enable and its horizontal and vertical syncs, and places the colour bits onto a 48-lane column data bus. The lane layout follows one of four formats. Two formats send one pixel per clock, either 6 or 8 bits per colour. The other two send two pixels per clock, again 6 or 8 bits per colour.

In the two-pixel formats the block joins consecutive pixels of a line into even/odd pairs. It raises a one-cycle strobe each time a complete pair is on the bus, so the strobe serves as a half-rate clock enable for the panel side. Data-enable and both syncs pass through the same single register stage as the data, so they stay aligned with it.

Top module: `pixel_lane_formatter`

## Requirements
- R1: While rst_n is low, and on the first clock after reset, out_data, out_strobe, out_de, out_hs and out_vs are all 0. The internal format starts at code 0.
- R2: The format code is captured from fmt_sel only on clocks where in_de is 0. A change of fmt_sel while in_de is 1 has no effect until in_de has been low for one clock. Codes: 0 = 18-bit single, 1 = 24-bit single, 2 = 36-bit pair, 3 = 48-bit pair.
- R3: Code 0 puts blue[7:2] on lanes 7:2, green[7:2] on lanes 15:10 and red[7:2] on lanes 23:18. Every other lane is 0.
- R4: Code 1 uses the code 0 lanes for colour bits 7:2. It also puts blue[1:0] on lanes 27:26, green[1:0] on lanes 29:28 and red[1:0] on lanes 31:30, with bit 1 on the higher lane. All other lanes are 0.
- R5: Code 3 puts the even pixel on lanes 23:0 and the odd pixel on lanes 47:24. Each pixel is laid out blue, green, red from low to high, 8 bits each, MSB on the highest lane.
- R6: Code 2 keeps the code 3 lane positions but carries only bits 7:2 of each colour. Lanes 0,1,8,9,16,17 and the same lanes plus 24 are 0.
- R7: Every line (a run of in_de = 1) starts a new pair, so its first pixel is always the even pixel.
- R8: If a line in a pair code has an odd pixel count, its last pixel goes out as an even pixel with lanes 47:24 at 0. This happens on the clock after the one where in_de first reads 0.
- R9: out_strobe is 1 for one clock per emitted word. In single codes that is the clock after each active input pixel. In pair codes it is the clock after each odd pixel, or after a flush. On every clock where out_strobe is 0, out_data is 0.
- R10: out_de, out_hs and out_vs equal in_de, in_hs and in_vs of the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Requested lane format code |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_blue | input | 8 | Blue component |
| in_green | input | 8 | Green component |
| in_red | input | 8 | Red component |
| out_data | output | 48 | Column data bus |
| out_strobe | output | 1 | Word-valid strobe / half-rate enable |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The hardest cases to reach are at line boundaries in the pair formats. One is a line with an odd pixel count followed by a blanking gap of exactly one clock. There the flush word and the first even pixel of the next line come close together. Another is a format change that arrives mid-line or right on the flush cycle. The stimulus runs lines of lengths 1, 2, 3, 5 and 8 with gaps of one to three clocks. It also moves fmt_sel while in_de is high and again on single-clock gaps. A behavioural queue model predicts every output on every clock.

// File: rtl/pixel_lane_formatter.sv
module pixel_lane_formatter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt_sel,
  input  logic        in_de,
  input  logic        in_hs,
  input  logic        in_vs,
  input  logic [7:0]  in_blue,
  input  logic [7:0]  in_green,
  input  logic [7:0]  in_red,
  output logic [47:0] out_data,
  output logic        out_strobe,
  output logic        out_de,
  output logic        out_hs,
  output logic        out_vs
);
  localparam logic [23:0] TOP6 = 24'hFCFCFC;

  logic [1:0]  mode_q;
  logic        odd_due;
  logic [23:0] even_q;

  wire         pair_mode = mode_q[1];
  wire         full_bits = mode_q[0];
  wire  [23:0] cur       = {in_red, in_green, in_blue};
  wire  [23:0] cur_fmt   = full_bits ? cur : (cur & TOP6);
  wire  [23:0] even_fmt  = full_bits ? even_q : (even_q & TOP6);
  wire  [23:0] odd_fmt   = in_de ? cur_fmt : 24'h0;
  wire  [5:0]  parked    = full_bits ? {in_red[1:0], in_green[1:0], in_blue[1:0]} : 6'h0;

  wire  [47:0] single_word = {16'h0, parked, 2'b00, cur & TOP6};
  wire  [47:0] pair_word   = {odd_fmt, even_fmt};

  wire emit_single = !pair_mode && in_de;
  wire emit_pair   = pair_mode && odd_due;
  wire take_even   = pair_mode && in_de && !odd_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 2'd0;
      odd_due    <= 1'b0;
      even_q     <= 24'h0;
      out_data   <= 48'h0;
      out_strobe <= 1'b0;
      out_de     <= 1'b0;
      out_hs     <= 1'b0;
      out_vs     <= 1'b0;
    end else begin
      out_strobe <= emit_single || emit_pair;
      out_data   <= emit_pair ? pair_word : (emit_single ? single_word : 48'h0);
      out_de     <= in_de;
      out_hs     <= in_hs;
      out_vs     <= in_vs;
      odd_due    <= take_even;
      if (take_even) even_q <= cur;
      if (!in_de)    mode_q <= fmt_sel;
    end
  end
endmodule

// File: rtl/pixel_lane_formatter_chk.sv
module pixel_lane_formatter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_q,
  input logic        in_de,
  input logic        in_hs,
  input logic        in_vs,
  input logic [47:0] out_data,
  input logic        out_strobe,
  input logic        out_de,
  input logic        out_hs,
  input logic        out_vs
);
  AST_DE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_de |=> out_de); // R10
  AST_DE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_de |=> !out_de); // R10
  AST_HS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_hs |=> out_hs); // R10
  AST_VS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_vs |=> out_vs); // R10
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n) !out_strobe |-> out_data == 48'h0); // R9
  AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (mode_q[1] && out_strobe) |=> !out_strobe); // R9
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && !$past(mode_q[1])) |-> (out_data[47:32] == 16'h0 && out_data[25:24] == 2'b00)); // R4
  AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && $past(mode_q) == 2'd0) |-> (out_data[47:24] == 24'h0 && (out_data[23:0] & 24'h030303) == 24'h0)); // R3
  AST_HALF_PAIR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && $past(mode_q) == 2'd2) |-> ((out_data & 48'h030303030303) == 48'h0)); // R6
endmodule

bind pixel_lane_formatter pixel_lane_formatter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
  .out_data(out_data), .out_strobe(out_strobe), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
);

// File: tb/test_pixel_lane_formatter.sv
module test_pixel_lane_formatter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt_sel = 2'd0;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [7:0] in_blue = 8'h0, in_green = 8'h0, in_red = 8'h0;
  logic [47:0] out_data;
  logic out_strobe, out_de, out_hs, out_vs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [47:0] e_data = 48'h0;
  logic e_strobe = 1'b0, e_de = 1'b0, e_hs = 1'b0, e_vs = 1'b0;
  string e_tag = "R1";
  string scene = "R1";
  int m_mode = 0;
  logic [23:0] m_q[$];

  always #(PERIOD/2) clk = ~clk;

  pixel_lane_formatter i_pixel_lane_formatter (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .in_blue(in_blue), .in_green(in_green), .in_red(in_red),
    .out_data(out_data), .out_strobe(out_strobe), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
  );

  function automatic logic [47:0] place(logic [23:0] pix, int base, bit low_too);
    logic [47:0] w = 48'h0;
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 8; b++)
        if (b >= 2 || low_too) w[base + c*8 + b] = pix[c*8 + b];
    return w;
  endfunction

  function automatic logic [47:0] park(logic [23:0] pix);
    logic [47:0] w = 48'h0;
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 2; b++) w[26 + 2*c + b] = pix[c*8 + b];
    return w;
  endfunction

  task automatic chk1(string tag, string what, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s got %h expected %h", tag, scene, what, got, exp);
    end
  endtask

  task automatic check_all();
    chk1(e_tag, "out_data", out_data, e_data);
    chk1("R9", "out_strobe", {47'h0, out_strobe}, {47'h0, e_strobe});
    chk1("R10", "out_de", {47'h0, out_de}, {47'h0, e_de});
    chk1("R10", "out_hs", {47'h0, out_hs}, {47'h0, e_hs});
    chk1("R10", "out_vs", {47'h0, out_vs}, {47'h0, e_vs});
  endtask

  task automatic model_step();
    logic [23:0] pix = {in_red, in_green, in_blue};
    e_de = in_de; e_hs = in_hs; e_vs = in_vs;
    e_strobe = 1'b0; e_data = 48'h0; e_tag = "R9";
    if (m_mode < 2) begin
      if (in_de) begin
        e_strobe = 1'b1;
        e_data = place(pix, 0, 1'b0);
        if (m_mode == 1) begin e_data |= park(pix); e_tag = "R4"; end
        else e_tag = "R3";
      end
    end else begin
      if (in_de) begin
        m_q.push_back(pix);
        if (m_q.size() == 2) begin
          e_strobe = 1'b1;
          e_data = place(m_q[0], 0, m_mode == 3) | place(m_q[1], 24, m_mode == 3);
          e_tag = (m_mode == 3) ? "R5" : "R6";
          m_q.delete();
        end
      end else if (m_q.size() == 1) begin
        e_strobe = 1'b1;
        e_data = place(m_q[0], 0, m_mode == 3);
        e_tag = "R8";
        m_q.delete();
      end
    end
    if (!in_de) begin
      m_q.delete();
      m_mode = fmt_sel;
    end
  endtask

  task automatic tick(bit de, logic [1:0] sel);
    @(negedge clk);
    cycles++;
    check_all();
    in_de = de;
    fmt_sel = sel;
    in_hs = 1'($urandom);
    in_vs = 1'($urandom);
    {in_red, in_green, in_blue} = de ? 24'($urandom) : 24'h0;
    model_step();
  endtask

  task automatic run_line(int len, int gap, logic [1:0] sel);
    for (int i = 0; i < len; i++) tick(1'b1, sel);
    for (int i = 0; i < gap; i++) tick(1'b0, sel);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk1("R1", "reset out_data", out_data, 48'h0);
      chk1("R1", "reset strobe/syncs", {44'h0, out_strobe, out_de, out_hs, out_vs}, 48'h0);
    end
    rst_n = 1'b1;
    for (int md = 0; md < 4; md++) begin
      scene = (md == 0) ? "R3" : (md == 1) ? "R4" : (md == 2) ? "R6" : "R5";
      tick(1'b0, 2'(md));
      tick(1'b0, 2'(md));
      run_line(8, 2, 2'(md));
      run_line(5, 3, 2'(md));
      run_line(1, 2, 2'(md));
      run_line(2, 1, 2'(md));
      run_line(3, 2, 2'(md));
    end
    scene = "R7";
    for (int md = 2; md < 4; md++) begin
      tick(1'b0, 2'(md));
      repeat (6) run_line(3, 1, 2'(md));
      repeat (4) run_line(1, 1, 2'(md));
    end
    scene = "R2";
    tick(1'b0, 2'd3);
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 5; i++) tick(1'b1, 2'($urandom));
      tick(1'b0, 2'(k % 4));
      if (k % 3 == 0) tick(1'b0, 2'($urandom));
    end
    scene = "R8";
    for (int k = 0; k < 200; k++) run_line(1 + ($urandom % 9), 1 + ($urandom % 3), 2'($urandom));
    tick(1'b0, 2'd0);
    tick(1'b0, 2'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule